// File: doc/BRIEF.md
# I2C Target Sequential Register Reader

This block is an I2C target that lets a bus master read a run of consecutive registers from an 8-bit register address space. The master first sets a register pointer with a short write transfer. It then issues a repeated START and a read-direction address. The target returns one byte per acknowledged slot, taken from the pointer address, and advances the pointer after each byte. The stream ends when the master declines a byte. At that point the target lets go of SDA so that the master can close the transfer with a STOP.

SCL and SDA arrive as open-drain line levels. Each passes through a synchronizer, and all protocol events are recovered from the synchronized levels in the system clock domain. The target never drives SCL. On SDA it only asserts a pull-down enable. The target's own 7-bit address is an input. Register contents come from an external register file through a combinational read port: the block presents an address, and the file returns a data byte and a flag that says whether that address is mapped. The pointer stops at FFh instead of wrapping around. Unmapped or exhausted addresses read as zero.

Top module: `i2c_blkrd_target`

## Requirements
- R1: After reset the SDA pull-down enable is inactive and the register pointer presented on `reg_addr` is 00h.
- R2: A START followed by the own 7-bit address with write bit 0 is acknowledged by pulling SDA low during the ninth clock. The following byte is acknowledged the same way and becomes the register pointer.
- R3: A 7-bit address (bits 7..1 of the first byte) that differs from `own_addr` is not acknowledged. SDA stays released, and the pointer stays unchanged, until the next START or STOP.
- R4: After a repeated START, the own address with read bit 1 is acknowledged. The target then shifts out the byte at the pointer address, most significant bit first.
- R5: Each data byte the master acknowledges (SDA low in the ninth clock) is followed by the byte at the next consecutive address, for as many bytes as the master keeps acknowledging.
- R6: A byte whose address has `reg_valid` low is sent as 00h, whatever `reg_data` carries.
- R7: The pointer never wraps from FFh to 00h. Once the byte at FFh has been sent, `reg_addr` stays FFh and every further byte in the burst is 00h.
- R8: When the master does not acknowledge a data byte (SDA high in the ninth clock), the target releases SDA from the following SCL low phase onward until the next START or STOP.
- R9: The SDA pull-down enable changes only while the synchronized SCL level is low.
- R10: A repeated START in the middle of any byte abandons that byte. The target then receives a fresh address byte.
- R11: A STOP returns the target to idle with SDA released. A later START begins a normal transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | SDA pull-down enable; 1 drives the line low |
| own_addr | input | 7 | 7-bit target address to respond to |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_data | input | 8 | Register file data at `reg_addr` |
| reg_valid | input | 1 | High when `reg_addr` is a mapped register |

## Verification
Most internal faults surface at SDA within a single byte slot. A bit counter that is off by one, or a state that fails to return to ACK, shows up at the next ninth clock as a missing or misplaced ACK, or as data shifted by one bit. A fault in the pointer or its saturation flag is subtler: the burst returns correct bytes until the run crosses FFh or an unmapped window, so bursts are placed to straddle both boundaries. A stuck drive enable after a NACK or an address mismatch is caught in the next SCL low phase, by reading `sda_oe` directly before the master issues STOP.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_TX,
    ST_TACK,
    ST_WAIT
  } tgt_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain, sda_chain;
  logic              scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_prev  <= 1'b1;
      sda_prev  <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_prev  <= scl_chain[STAGES-1];
      sda_prev  <= sda_chain[STAGES-1];
    end
  end

  assign scl_lvl   = scl_chain[STAGES-1];
  assign sda_lvl   = sda_chain[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  // SDA edges while SCL stays high mark bus conditions
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2c_blk_ptr.sv
module i2c_blk_ptr #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_val,
  input  logic          inc_en,
  input  logic [DW-1:0] reg_data,
  input  logic          reg_valid,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] rd_byte
);
  localparam logic [AW-1:0] PTR_TOP = '1;

  logic [AW-1:0] ptr_q, ptr_d;
  logic          end_q, end_d;

  always_comb begin
    ptr_d = ptr_q;
    end_d = end_q;
    if (wr_en) begin
      ptr_d = wr_val;
      end_d = 1'b0;
    end else if (inc_en) begin
      if (ptr_q == PTR_TOP) end_d = 1'b1;
      else                  ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      end_q <= 1'b0;
    end else if (wr_en | inc_en) begin
      ptr_q <= ptr_d;
      end_q <= end_d;
    end
  end

  assign ptr     = ptr_q;
  assign rd_byte = (end_q | ~reg_valid) ? '0 : reg_data;

  assert_ptr_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr_q) == PTR_TOP && !$past(wr_en)) |-> ptr_q == PTR_TOP);
endmodule

// File: rtl/i2c_blk_fsm.sv
module i2c_blk_fsm
  import i2c_blk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              ptr_wr,
  output logic [BYTE_W-1:0] ptr_val,
  output logic              ptr_inc,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  tgt_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              rw_q, rw_d, ack_q, ack_d, drv_q, drv_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    ack_d   = ack_q;
    ptr_wr  = 1'b0;
    ptr_inc = 1'b0;
    if (stop_det) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else if (start_det) begin
      st_d  = ST_ADDR;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_PTR: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall && cnt_q == CNT_FULL) begin
            cnt_d = '0;
            if (st_q == ST_PTR) begin
              ptr_wr = 1'b1;
              st_d   = ST_PACK;
            end else if (sh_q[BYTE_W-1:1] == own_addr) begin
              rw_d = sh_q[0];
              st_d = ST_AACK;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_d = '0;
          if (rw_q) begin
            st_d = ST_TX;
            sh_d = rd_byte;
          end else begin
            st_d = ST_PTR;
          end
        end
        ST_PACK: if (scl_fall) st_d = ST_WAIT;
        ST_TX: begin
          if (scl_rise && cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
          if (scl_fall && cnt_q != '0) begin
            if (cnt_q == CNT_FULL) begin
              st_d    = ST_TACK;
              ptr_inc = 1'b1;
            end else begin
              sh_d = {sh_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) ack_d = ~sda_lvl;
          if (scl_fall) begin
            if (ack_q) begin
              st_d  = ST_TX;
              sh_d  = rd_byte;
              cnt_d = '0;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
    drv_d = (st_d == ST_AACK) || (st_d == ST_PACK) ||
            ((st_d == ST_TX) && !sh_d[BYTE_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      rw_q  <= 1'b0;
      ack_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      rw_q  <= rw_d;
      ack_q <= ack_d;
      drv_q <= drv_d;
    end
  end

  assign ptr_val = sh_q;
  assign sda_oe  = drv_q;

  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_q) |-> !scl_lvl);
  assert_mismatch_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT) |-> !drv_q);
  assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TACK && scl_fall && !ack_q && !start_det && !stop_det)
      |=> (!drv_q && st_q == ST_WAIT));
  assert_restart_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st_q == ST_ADDR && cnt_q == '0));
  assert_stop_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st_q == ST_IDLE && !drv_q));
endmodule

// File: rtl/i2c_blkrd_target.sv
module i2c_blkrd_target
  import i2c_blk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  output logic [BYTE_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_data,
  input  logic              reg_valid
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_wr, ptr_inc;
  logic [BYTE_W-1:0] ptr_val, rd_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_blk_ptr #(.AW(BYTE_W), .DW(BYTE_W)) u_ptr (
    .clk(clk), .rst_n(rst_s_n), .wr_en(ptr_wr), .wr_val(ptr_val),
    .inc_en(ptr_inc), .reg_data(reg_data), .reg_valid(reg_valid),
    .ptr(reg_addr), .rd_byte(rd_byte)
  );

  i2c_blk_fsm u_fsm (
    .clk(clk), .rst_n(rst_s_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .own_addr(own_addr), .rd_byte(rd_byte),
    .ptr_wr(ptr_wr), .ptr_val(ptr_val), .ptr_inc(ptr_inc), .sda_oe(sda_oe)
  );
endmodule

// File: tb/sim_i2c_blkrd_target.sv
module sim_i2c_blkrd_target;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 8;
  localparam logic [6:0] MY_ADDR = 7'h2C;
  localparam int NVEC = 6;
  // {start pointer, byte count}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0003, 16'h3E04, 16'hFD05, 16'h8002, 16'hFF03, 16'h4F02
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, sda_line, reg_valid;
  logic [7:0] reg_addr, reg_data;
  int checks = 0;
  int fails = 0;
  int r9_bad = 0;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_valid = !(reg_addr >= 8'h40 && reg_addr <= 8'h4F);
  assign reg_data  = reg_valid ? (reg_addr ^ 8'h5A) : 8'hC3;

  i2c_blkrd_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .own_addr(MY_ADDR), .reg_addr(reg_addr),
    .reg_data(reg_data), .reg_valid(reg_valid)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe !== prev_oe && scl_m) r9_bad++;
      prev_oe <= sda_oe;
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int a);
    if (a > 255) return 8'h00;
    if (a >= 'h40 && a <= 'h4F) return 8'h00;
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
    ack = ~sda_line;
    qwait(); scl_m = 1'b0; qwait();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic [7:0] acc = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qwait(); scl_m = 1'b1; qwait();
      acc = {acc[6:0], sda_line};
      qwait(); scl_m = 1'b0;
    end
    qwait();
    sda_m = ~give_ack; qwait(); scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait(); sda_m = 1'b1;
    d = acc;
  endtask

  task automatic set_ptr(input logic [7:0] p, input string tag);
    logic ack;
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    check(ack, {tag, " address+W ack"}, ack, 1);
    send_byte(p, ack);
    check(ack, {tag, " pointer ack"}, ack, 1);
  endtask

  task automatic burst(input int p, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    check(ack, "R4 address+R ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, d);
      check(d == exp_byte(p + i), tag, d, exp_byte(p + i));
    end
    check(!sda_oe, "R8 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    logic [7:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    check(!sda_oe, "R1 sda released", sda_oe, 0);
    check(reg_addr == 8'h00, "R1 pointer zero", reg_addr, 0);

    // Table walk: R2 pointer write, R4/R5 stream, R6 unmapped, R7 saturation
    for (int v = 0; v < NVEC; v++) begin
      set_ptr(VEC[v][15:8], "R2");
      burst(int'(VEC[v][15:8]), int'(VEC[v][7:0]), "R5/R6/R7 burst data");
    end

    // R7: pointer held at FFh after running past the end
    set_ptr(8'hFE, "R2");
    burst('hFE, 4, "R7 past-end data");
    check(reg_addr == 8'hFF, "R7 pointer saturated", reg_addr, 8'hFF);

    // R3: wrong address is ignored
    set_ptr(8'h10, "R2");
    bus_stop();
    held = reg_addr;
    bus_start();
    send_byte({7'h2D, 1'b0}, ack);
    check(!ack, "R3 no ack on mismatch", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R3 still released", ack, 0);
    check(reg_addr == held, "R3 pointer kept", reg_addr, held);
    bus_stop();

    // R10: repeated START in the middle of the pointer byte
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    check(ack, "R10 address after abort", ack, 1);
    send_byte(8'h20, ack);
    check(ack, "R10 pointer after abort", ack, 1);
    burst('h20, 2, "R10 data after abort");

    // R10: repeated START during a data byte
    set_ptr(8'h30, "R2");
    bus_start();
    send_byte({MY_ADDR, 1'b1}, ack);
    sda_m = 1'b1;
    for (int i = 0; i < 3; i++) begin
      qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0;
    end
    qwait();
    while (!sda_line) begin   // wait for a released bit slot
      qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    end
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    check(ack, "R10 address after data abort", ack, 1);
    bus_stop();

    // R11: STOP right after the address returns to idle
    bus_start();
    send_byte({MY_ADDR, 1'b0}, ack);
    bus_stop();
    qwait();
    check(!sda_oe, "R11 idle after stop", sda_oe, 0);
    set_ptr(8'h05, "R11");
    burst('h05, 1, "R11 data after stop");

    check(r9_bad == 0, "R9 sda changes only with scl low", r9_bad, 0);
    d = 8'h00;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails + 0 * int'(d));
    $finish;
  end
endmodule